// File: doc/BRIEF.md
# Multicycle Processor Main Control Sequencer

This block is the main control state machine of a multicycle 32-bit processor. Each instruction takes several clock cycles. The block walks through fetch, decode and one or more execution states. In each state it drives the multiplexer selects, the ALU operation class and the write strobes that the datapath needs for that step. The inputs are the opcode and function fields of the instruction register. The block supports these instruction classes: load word, store word, register-register ALU operations, add-immediate, branch-if-equal and jump.

The block also supports a variable arithmetic right shift (opcode 000000, function 000111). This instruction does not use the ALU. A dedicated shifter beside the ALU computes the result. A shift-execute state captures that result into a holding register, and a shift writeback state steers it to the register file through a third write-back source.

The instruction register loads during fetch. Its opcode and function fields must stay stable from decode until the sequencer is back in fetch. The block has no data stream of its own, so every pin is a plain level signal. The present state is brought out as a 4-bit code so that the surrounding logic and the tests can observe the sequence.

Top module: `rc_main_ctrl`

## Requirements
- R1: While the active-low reset `rst_n` is low, the state is fetch (code 0). This holds immediately, without waiting for a clock. The first cycle after release is a fetch.
- R2: Fetch drives iord_sel=0, alu_a_sel=0, alu_b_sel=01, alu_op=00, pc_src=00, ir_wr=1 and pc_wr=1. Fetch is always followed by decode (code 1).
- R3: Decode drives alu_a_sel=0, alu_b_sel=11 and alu_op=00, and asserts no write strobe.
- R4: From decode, the next state depends on the opcode. Opcode 100011 (load) and opcode 101011 (store) go to address (code 2). Opcode 000000 with any function other than 000111 goes to execute (code 6). Opcode 001000 goes to immediate-execute (code 9). Opcode 000100 goes to branch (code 8). Opcode 000010 goes to jump (code 11). Any other opcode goes back to fetch.
- R5: The load path is address, then read (code 3, iord_sel=1), then load writeback (code 4, rd_sel=0, wb_src=01, rf_wr=1). The address state drives alu_a_sel=1, alu_b_sel=10 and alu_op=00.
- R6: The store path is address, then memory write (code 5, iord_sel=1, mem_wr=1).
- R7: Execute drives alu_a_sel=1, alu_b_sel=00 and alu_op=10. It is followed by ALU writeback (code 7, rd_sel=1, wb_src=00, rf_wr=1).
- R8: Immediate-execute drives alu_a_sel=1, alu_b_sel=10 and alu_op=00. It is followed by immediate writeback (code 10, rd_sel=0, wb_src=00, rf_wr=1).
- R9: Branch drives alu_a_sel=1, alu_b_sel=00, alu_op=01, pc_src=01 and br_en=1, with pc_wr=0. Jump drives pc_src=10 and pc_wr=1.
- R10: Opcode 000000 with function 000111 goes from decode to shift-execute (code 12). Shift-execute asserts shift_ld and leaves every ALU control at 0. Shift-execute is followed by shift writeback (code 13, rd_sel=1, wb_src=10, rf_wr=1).
- R11: Every terminal state (codes 4, 5, 7, 8, 10, 11, 13) is followed by fetch.
- R12: In any cycle at most one of rf_wr, mem_wr and ir_wr is high. In each state, every control that the state does not name is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| fsm_state | output | 4 | Present state code |
| iord_sel | output | 1 | Memory address select: 0 = PC, 1 = ALU result register |
| alu_a_sel | output | 1 | ALU A select: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B select: 00 = register B, 01 = 4, 10 = immediate, 11 = shifted immediate |
| alu_op | output | 2 | ALU operation class: 00 = add, 01 = subtract, 10 = by function field |
| pc_src | output | 2 | Next PC select: 00 = ALU, 01 = ALU result register, 10 = jump target |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC write |
| br_en | output | 1 | PC write if the ALU zero flag is set |
| rd_sel | output | 1 | Destination register select: 0 = rt, 1 = rd |
| wb_src | output | 2 | Write-back source: 00 = ALU result, 01 = memory data, 10 = shift result |
| rf_wr | output | 1 | Register file write |
| mem_wr | output | 1 | Memory write |
| shift_ld | output | 1 | Load the shifter result into the shift holding register |

## Verification
On every cycle the assertions check these properties: the reset entry, the fetch-to-decode step, the routing of the shift instruction into its own execute state and the shape of its writeback, the return to fetch after any writing or PC-changing step, and the limit of one storage write per cycle. Only the bench's scenarios can show the full cycle count of each instruction path, the complete control vector of every state, and the routing of each opcode. This includes a register-register opcode whose function field lies next to the shift code, and an unassigned opcode. A reset asserted in the middle of a load is also covered only by the scenarios.

// File: rtl/rc_ctrl_pkg.sv
package rc_ctrl_pkg;

  localparam int OPC_W = 6;
  localparam int FN_W  = 6;
  localparam int ST_W  = 4;

  localparam logic [OPC_W-1:0] OPC_RTYPE = 6'b000000;
  localparam logic [OPC_W-1:0] OPC_LOAD  = 6'b100011;
  localparam logic [OPC_W-1:0] OPC_STORE = 6'b101011;
  localparam logic [OPC_W-1:0] OPC_ADDIM = 6'b001000;
  localparam logic [OPC_W-1:0] OPC_BREQ  = 6'b000100;
  localparam logic [OPC_W-1:0] OPC_JUMP  = 6'b000010;
  localparam logic [FN_W-1:0]  FN_SHRAV  = 6'b000111;

  typedef enum logic [ST_W-1:0] {
    ST_FETCH  = 4'd0,
    ST_DECODE = 4'd1,
    ST_MADDR  = 4'd2,
    ST_MREAD  = 4'd3,
    ST_LDWB   = 4'd4,
    ST_MWRITE = 4'd5,
    ST_EXEC   = 4'd6,
    ST_ALUWB  = 4'd7,
    ST_BRANCH = 4'd8,
    ST_IMEXEC = 4'd9,
    ST_IMWB   = 4'd10,
    ST_JUMP   = 4'd11,
    ST_SHEXEC = 4'd12,
    ST_SHWB   = 4'd13
  } state_e;

  typedef enum logic [2:0] {
    CL_MEM    = 3'd0,
    CL_RTYPE  = 3'd1,
    CL_SHIFT  = 3'd2,
    CL_IMM    = 3'd3,
    CL_BRANCH = 3'd4,
    CL_JUMP   = 3'd5,
    CL_NONE   = 3'd6
  } iclass_e;

  localparam logic [1:0] WB_ALU   = 2'b00;
  localparam logic [1:0] WB_MEM   = 2'b01;
  localparam logic [1:0] WB_SHIFT = 2'b10;

  typedef struct packed {
    logic       iord;
    logic       alua;
    logic [1:0] alub;
    logic [1:0] aluop;
    logic [1:0] pcsrc;
    logic       irwr;
    logic       pcwr;
    logic       br;
    logic       rdsel;
    logic [1:0] wbsrc;
    logic       rfwr;
    logic       memwr;
    logic       shld;
  } ctrl_t;

endpackage

// File: rtl/rc_op_classify.sv
module rc_op_classify
  import rc_ctrl_pkg::*;
#(
  parameter int OW = OPC_W,
  parameter int FW = FN_W
) (
  input  logic [OW-1:0] opcode,
  input  logic [FW-1:0] funct,
  output iclass_e       iclass,
  output logic          is_store
);

  always_comb begin
    iclass   = CL_NONE;
    is_store = (opcode == OPC_STORE);
    unique case (opcode)
      OPC_LOAD, OPC_STORE: iclass = CL_MEM;
      OPC_RTYPE:           iclass = (funct == FN_SHRAV) ? CL_SHIFT : CL_RTYPE;
      OPC_ADDIM:           iclass = CL_IMM;
      OPC_BREQ:            iclass = CL_BRANCH;
      OPC_JUMP:            iclass = CL_JUMP;
      default:             iclass = CL_NONE;
    endcase
  end

endmodule

// File: rtl/rc_state_seq.sv
module rc_state_seq
  import rc_ctrl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_e iclass,
  input  logic    is_store,
  output state_e  state
);

  state_e nxt;

  always_comb begin
    nxt = ST_FETCH;
    unique case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        unique case (iclass)
          CL_MEM:    nxt = ST_MADDR;
          CL_RTYPE:  nxt = ST_EXEC;
          CL_SHIFT:  nxt = ST_SHEXEC;
          CL_IMM:    nxt = ST_IMEXEC;
          CL_BRANCH: nxt = ST_BRANCH;
          CL_JUMP:   nxt = ST_JUMP;
          default:   nxt = ST_FETCH;
        endcase
      end
      ST_MADDR: begin
        if (iclass != CL_MEM) nxt = ST_FETCH;
        else if (is_store)    nxt = ST_MWRITE;
        else                  nxt = ST_MREAD;
      end
      ST_MREAD:  nxt = ST_LDWB;
      ST_EXEC:   nxt = ST_ALUWB;
      ST_IMEXEC: nxt = ST_IMWB;
      ST_SHEXEC: nxt = ST_SHWB;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

endmodule

// File: rtl/rc_ctrl_decode.sv
module rc_ctrl_decode
  import rc_ctrl_pkg::*;
(
  input  state_e state,
  output ctrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_FETCH: begin
        ctrl.alub = 2'b01;
        ctrl.irwr = 1'b1;
        ctrl.pcwr = 1'b1;
      end
      ST_DECODE: ctrl.alub = 2'b11;
      ST_MADDR: begin
        ctrl.alua = 1'b1;
        ctrl.alub = 2'b10;
      end
      ST_MREAD: ctrl.iord = 1'b1;
      ST_LDWB: begin
        ctrl.wbsrc = WB_MEM;
        ctrl.rfwr  = 1'b1;
      end
      ST_MWRITE: begin
        ctrl.iord  = 1'b1;
        ctrl.memwr = 1'b1;
      end
      ST_EXEC: begin
        ctrl.alua  = 1'b1;
        ctrl.aluop = 2'b10;
      end
      ST_ALUWB: begin
        ctrl.rdsel = 1'b1;
        ctrl.wbsrc = WB_ALU;
        ctrl.rfwr  = 1'b1;
      end
      ST_BRANCH: begin
        ctrl.alua  = 1'b1;
        ctrl.aluop = 2'b01;
        ctrl.pcsrc = 2'b01;
        ctrl.br    = 1'b1;
      end
      ST_IMEXEC: begin
        ctrl.alua = 1'b1;
        ctrl.alub = 2'b10;
      end
      ST_IMWB: ctrl.rfwr = 1'b1;
      ST_JUMP: begin
        ctrl.pcsrc = 2'b10;
        ctrl.pcwr  = 1'b1;
      end
      ST_SHEXEC: ctrl.shld = 1'b1;
      ST_SHWB: begin
        ctrl.rdsel = 1'b1;
        ctrl.wbsrc = WB_SHIFT;
        ctrl.rfwr  = 1'b1;
      end
      default: ctrl = '0;
    endcase
  end

endmodule

// File: rtl/rc_main_ctrl.sv
module rc_main_ctrl
  import rc_ctrl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  input  logic [FN_W-1:0]  funct,
  output logic [ST_W-1:0]  fsm_state,
  output logic             iord_sel,
  output logic             alu_a_sel,
  output logic [1:0]       alu_b_sel,
  output logic [1:0]       alu_op,
  output logic [1:0]       pc_src,
  output logic             ir_wr,
  output logic             pc_wr,
  output logic             br_en,
  output logic             rd_sel,
  output logic [1:0]       wb_src,
  output logic             rf_wr,
  output logic             mem_wr,
  output logic             shift_ld
);

  iclass_e iclass;
  logic    is_store;
  state_e  state;
  ctrl_t   ctrl;

  rc_op_classify #(.OW(OPC_W), .FW(FN_W)) u_cls (
    .opcode   (opcode),
    .funct    (funct),
    .iclass   (iclass),
    .is_store (is_store)
  );

  rc_state_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .iclass   (iclass),
    .is_store (is_store),
    .state    (state)
  );

  rc_ctrl_decode u_dec (
    .state (state),
    .ctrl  (ctrl)
  );

  assign fsm_state = state;
  assign iord_sel  = ctrl.iord;
  assign alu_a_sel = ctrl.alua;
  assign alu_b_sel = ctrl.alub;
  assign alu_op    = ctrl.aluop;
  assign pc_src    = ctrl.pcsrc;
  assign ir_wr     = ctrl.irwr;
  assign pc_wr     = ctrl.pcwr;
  assign br_en     = ctrl.br;
  assign rd_sel    = ctrl.rdsel;
  assign wb_src    = ctrl.wbsrc;
  assign rf_wr     = ctrl.rfwr;
  assign mem_wr    = ctrl.memwr;
  assign shift_ld  = ctrl.shld;

endmodule

// File: rtl/rc_main_ctrl_chk.sv
module rc_main_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [5:0] opcode,
  input logic [5:0] funct,
  input logic [3:0] fsm_state,
  input logic [1:0] pc_src,
  input logic       ir_wr,
  input logic       pc_wr,
  input logic       br_en,
  input logic       rd_sel,
  input logic [1:0] wb_src,
  input logic       rf_wr,
  input logic       mem_wr,
  input logic       shift_ld,
  input logic [1:0] alu_op
);

  AST_RESET_FETCH: assert property (@(posedge clk)
    !rst_n |=> (fsm_state == 4'd0 && ir_wr && pc_wr)); // R1

  AST_FETCH_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 4'd0) |=> (fsm_state == 4'd1)); // R2

  AST_SHIFT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (fsm_state == 4'd1 && opcode == 6'b000000 && funct == 6'b000111) |=> shift_ld); // R10

  AST_SHIFT_WB: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ld |=> (rf_wr && rd_sel && wb_src == 2'b10 && alu_op == 2'b00)); // R10

  AST_TERM_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_wr || mem_wr || br_en || pc_src == 2'b10) |=> (fsm_state == 4'd0)); // R11

  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rf_wr, mem_wr, ir_wr})); // R12

endmodule

bind rc_main_ctrl rc_main_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .opcode    (opcode),
  .funct     (funct),
  .fsm_state (fsm_state),
  .pc_src    (pc_src),
  .ir_wr     (ir_wr),
  .pc_wr     (pc_wr),
  .br_en     (br_en),
  .rd_sel    (rd_sel),
  .wb_src    (wb_src),
  .rf_wr     (rf_wr),
  .mem_wr    (mem_wr),
  .shift_ld  (shift_ld),
  .alu_op    (alu_op)
);

// File: tb/rc_main_ctrl_bench.sv
module rc_main_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] opcode = '0;
  logic [5:0] funct = '0;
  logic [3:0] fsm_state;
  logic       iord_sel, alu_a_sel, ir_wr, pc_wr, br_en, rd_sel, rf_wr, mem_wr, shift_ld;
  logic [1:0] alu_b_sel, alu_op, pc_src, wb_src;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic [3:0] exp_st;

  always #10 clk = ~clk;

  rc_main_ctrl u_rc_main_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct),
    .fsm_state(fsm_state), .iord_sel(iord_sel), .alu_a_sel(alu_a_sel),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op), .pc_src(pc_src), .ir_wr(ir_wr),
    .pc_wr(pc_wr), .br_en(br_en), .rd_sel(rd_sel), .wb_src(wb_src),
    .rf_wr(rf_wr), .mem_wr(mem_wr), .shift_ld(shift_ld)
  );

  // order: iord alua alub aluop pcsrc irwr pcwr br rdsel wbsrc rfwr memwr shld
  function automatic logic [17:0] exp_ctrl(input logic [3:0] s);
    logic iord, alua, irwr, pcwr, br, rdsel, rfwr, memwr, shld;
    logic [1:0] alub, aluop, pcsrc, wbsrc;
    {iord, alua, irwr, pcwr, br, rdsel, rfwr, memwr, shld} = '0;
    {alub, aluop, pcsrc, wbsrc} = '0;
    case (s)
      4'd0:  begin alub = 2'b01; irwr = 1; pcwr = 1; end
      4'd1:  alub = 2'b11;
      4'd2:  begin alua = 1; alub = 2'b10; end
      4'd3:  iord = 1;
      4'd4:  begin wbsrc = 2'b01; rfwr = 1; end
      4'd5:  begin iord = 1; memwr = 1; end
      4'd6:  begin alua = 1; aluop = 2'b10; end
      4'd7:  begin rdsel = 1; rfwr = 1; end
      4'd8:  begin alua = 1; aluop = 2'b01; pcsrc = 2'b01; br = 1; end
      4'd9:  begin alua = 1; alub = 2'b10; end
      4'd10: rfwr = 1;
      4'd11: begin pcsrc = 2'b10; pcwr = 1; end
      4'd12: shld = 1;
      4'd13: begin rdsel = 1; wbsrc = 2'b10; rfwr = 1; end
      default: ;
    endcase
    return {iord, alua, alub, aluop, pcsrc, irwr, pcwr, br, rdsel, wbsrc, rfwr, memwr, shld};
  endfunction

  function automatic logic [3:0] exp_next(input logic [3:0] s, input logic [5:0] op,
                                          input logic [5:0] fn);
    case (s)
      4'd0: return 4'd1;
      4'd1: case (op)
        6'b100011, 6'b101011: return 4'd2;
        6'b000000: return (fn == 6'b000111) ? 4'd12 : 4'd6;
        6'b001000: return 4'd9;
        6'b000100: return 4'd8;
        6'b000010: return 4'd11;
        default:   return 4'd0;
      endcase
      4'd2: return (op == 6'b101011) ? 4'd5 : 4'd3;
      4'd3: return 4'd4;
      4'd6: return 4'd7;
      4'd9: return 4'd10;
      4'd12: return 4'd13;
      default: return 4'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] s);
    case (s)
      4'd0: return "R2";  4'd1: return "R3";
      4'd2, 4'd3, 4'd4: return "R5";  4'd5: return "R6";
      4'd6, 4'd7: return "R7";  4'd9, 4'd10: return "R8";
      4'd8, 4'd11: return "R9";  default: return "R10";
    endcase
  endfunction

  function automatic string trans_tag(input logic [3:0] p);
    case (p)
      4'd0: return "R2";
      4'd1: return "R4";
      4'd4, 4'd5, 4'd7, 4'd8, 4'd10, 4'd11, 4'd13: return "R11";
      4'd12: return "R10";
      4'd6: return "R7";
      4'd9: return "R8";
      default: return "R5";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h time=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [17:0] act_ctrl();
    return {iord_sel, alu_a_sel, alu_b_sel, alu_op, pc_src, ir_wr, pc_wr, br_en,
            rd_sel, wb_src, rf_wr, mem_wr, shift_ld};
  endfunction

  // at a negedge: check present state, then advance one clock
  task automatic step(input string stag);
    logic [3:0] prev;
    chk(stag, {28'd0, fsm_state}, {28'd0, exp_st});
    chk(tag_of(exp_st), {14'd0, act_ctrl()}, {14'd0, exp_ctrl(exp_st)});
    chk("R12", {31'd0, $onehot0({rf_wr, mem_wr, ir_wr})}, 32'd1);
    prev = exp_st;
    @(posedge clk);
    exp_st = exp_next(prev, opcode, funct);
    @(negedge clk);
  endtask

  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input string stag);
    logic [3:0] prev;
    opcode = op; funct = fn;
    prev = 4'd0;
    step(stag);                      // fetch
    for (int i = 0; i < 6 && exp_st != 4'd0; i++) begin
      prev = exp_st;
      step(trans_tag(prev));
    end
    chk(trans_tag(prev), {28'd0, fsm_state}, 32'd0);
  endtask

  initial begin
    exp_st = 4'd0;
    repeat (2) @(negedge clk);
    chk("R1", {28'd0, fsm_state}, 32'd0);
    chk("R1", {14'd0, act_ctrl()}, {14'd0, exp_ctrl(4'd0)});
    rst_n = 1'b1;
    run_instr(6'b100011, 6'd0, "R1");      // load R5
    run_instr(6'b101011, 6'd0, "R6");      // store
    run_instr(6'b000000, 6'b100000, "R7"); // add
    run_instr(6'b000000, 6'b000110, "R4"); // neighbour of shift code
    run_instr(6'b000000, 6'b000111, "R10");// shift
    run_instr(6'b001000, 6'd0, "R8");
    run_instr(6'b000100, 6'd0, "R9");
    run_instr(6'b000010, 6'd0, "R9");
    run_instr(6'b111111, 6'd0, "R4");      // unassigned opcode
    // reset mid-load, asynchronous
    opcode = 6'b100011;
    step("R5"); step("R4"); step("R5");    // now in read
    chk("R5", {28'd0, fsm_state}, 32'd3);
    #5 rst_n = 1'b0;
    #1 chk("R1", {28'd0, fsm_state}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1; exp_st = 4'd0;
    // constrained random
    begin
      logic [5:0] ops [7];
      int seed;
      ops = '{6'b100011, 6'b101011, 6'b000000, 6'b001000, 6'b000100, 6'b000010, 6'b010101};
      seed = $urandom(32'h5eed);
      for (int n = 0; n < 3000; n++) begin
        if (exp_st == 4'd0) begin
          opcode = ops[$urandom_range(0, 6)];
          funct  = ($urandom_range(0, 2) == 0) ? 6'b000111 : 6'($urandom_range(0, 63));
        end
        step(trans_tag(exp_st));
      end
    end
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule